// File: doc/BRIEF.md
# Instruction Fetch Address and Pointer Correction Unit

This unit sits on the bus side of a processor front end. It keeps the instruction pointer and a code segment base. A dedicated adder forms the physical address of the next instruction byte from these two registers. The address is offered to the bus side as a valid/ready stream. Each accepted fetch advances the instruction pointer by one, so the pointer always names the next byte to be *fetched*. That position is ahead of the byte being executed by however many bytes sit in the prefetch queue.

Two commands change the pointer. A correction strobe carries the current queue occupancy. It pulls the pointer back by that many bytes so that it names the next byte to *execute*, which is what a call or relative branch needs. The amount is read from a small generated constant table that holds the negated occupancy, and it is applied on the offset adder.

A jump-load arrives as a valid/ready transfer carrying a new pointer and segment. It loads both registers and raises a one-cycle flush request towards the queue. Only one operation updates the pointer in a cycle. Correction beats jump-load, and jump-load beats fetch.

Back-pressure rules:
- The fetch offer may be held off by the bus with `fa_ready` low, and the pointer then stays put.
- The offer is withdrawn while a command owns the adder.
- A jump-load request must be held until `jmp_ready` is seen high at a clock edge.

Top module: `fetch_addr_unit`

## Requirements
- R1: During and right after reset the pointer is `RESET_IP` (0x0000), the segment is `RESET_CS` (0xFFFF), the fetch address is 0xFFFF0 and `flush_req` is low.
- R2: `fa_addr` always equals (segment × 16 + pointer) truncated to 20 bits.
- R3: `fa_valid` is high exactly when `q_room` is high, `corr_req` is low and `jmp_valid` is low. While `fa_valid` is high and `fa_ready` is low, the pointer does not change.
- R4: A fetch handshake (`fa_valid` and `fa_ready` high at an edge) adds one to the pointer at that edge, modulo 2^16, so 0xFFFF becomes 0x0000.
- R5: A correction strobe with `q_len` from 0 to `QDEPTH` (4) subtracts `q_len` from the pointer at that edge, modulo 2^16. A `q_len` above `QDEPTH` leaves the pointer unchanged.
- R6: While `corr_req` is high, `jmp_ready` and `fa_valid` are low. A jump-load or fetch presented in that cycle is not taken, and the segment is unchanged.
- R7: An accepted jump-load (`jmp_valid` and `jmp_ready`) writes `jmp_ip` and `jmp_cs` at that edge. `flush_req` is then high for exactly the following cycle.
- R8: Physical address arithmetic wraps at 20 bits: segment 0xFFFF with pointer 0x0010 gives address 0x00000.
- R9: With no handshake and no command, the pointer and segment hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_room | input | 1 | Prefetch queue has space for one byte |
| fa_valid | output | 1 | Fetch address offered |
| fa_ready | input | 1 | Bus takes the offered fetch address |
| fa_addr | output | 20 | Physical fetch address |
| corr_req | input | 1 | Correction strobe |
| q_len | input | 3 | Current queue occupancy for correction |
| jmp_valid | input | 1 | Jump-load request |
| jmp_ready | output | 1 | Jump-load accepted this cycle |
| jmp_ip | input | 16 | New pointer value |
| jmp_cs | input | 16 | New segment value |
| ip | output | 16 | Current instruction pointer |
| cs | output | 16 | Current code segment |
| flush_req | output | 1 | One-cycle queue flush request |

## Verification
A correction, a jump-load and a ready fetch can all be presented in the same cycle, with the bus ready and the queue having room. The bench drives all three together. Before the edge it checks that both the jump-load ready and the fetch offer are low. After the edge it checks that the pointer moved by exactly the corrected amount and that the segment and flush line were left untouched. It then presents the jump-load alone and judges that it is taken only once the correction is gone.

// File: rtl/fau_pkg.sv
package fau_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_INC  = 2'd1,
    OP_CORR = 2'd2,
    OP_LOAD = 2'd3
  } fau_op_e;
endpackage

// File: rtl/fau_const_rom.sv
module fau_const_rom #(
  parameter int IP_W   = 16,
  parameter int QDEPTH = 4,
  parameter int QL_W   = 3
) (
  input  logic [QL_W-1:0] qlen,
  output logic [IP_W-1:0] corr_k
);
  localparam int ENTRIES = QDEPTH + 1;

  // Entry k holds the two's complement of k, so the adder only ever adds.
  logic [IP_W-1:0] tbl [ENTRIES];

  for (genvar k = 0; k < ENTRIES; k++) begin : g_entry
    assign tbl[k] = {IP_W{1'b0}} - IP_W'(k);
  end

  always_comb begin
    corr_k = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      if (qlen == QL_W'(k)) corr_k = tbl[k];
    end
  end
endmodule

// File: rtl/fau_arbiter.sv
module fau_arbiter
  import fau_pkg::*;
(
  input  logic    rst_n,
  input  logic    corr_req,
  input  logic    jmp_valid,
  input  logic    q_room,
  input  logic    fa_ready,
  output logic    jmp_ready,
  output logic    fa_valid,
  output fau_op_e op
);
  always_comb begin
    jmp_ready = rst_n & ~corr_req;
    fa_valid  = rst_n & q_room & ~corr_req & ~jmp_valid;
    if (!rst_n)                     op = OP_HOLD;
    else if (corr_req)              op = OP_CORR;
    else if (jmp_valid)             op = OP_LOAD;
    else if (fa_valid && fa_ready)  op = OP_INC;
    else                            op = OP_HOLD;
  end
endmodule

// File: rtl/fau_off_adder.sv
module fau_off_adder
  import fau_pkg::*;
#(
  parameter int IP_W = 16
) (
  input  fau_op_e         op,
  input  logic [IP_W-1:0] ip_cur,
  input  logic [IP_W-1:0] corr_k,
  input  logic [IP_W-1:0] load_val,
  output logic [IP_W-1:0] ip_next
);
  logic [IP_W-1:0] opa, opb;

  always_comb begin
    opa = ip_cur;
    opb = '0;
    unique case (op)
      OP_INC:  opb = IP_W'(1);
      OP_CORR: opb = corr_k;
      OP_LOAD: begin opa = '0; opb = load_val; end
      default: opb = '0;
    endcase
  end

  assign ip_next = opa + opb;
endmodule

// File: rtl/fau_phys_adder.sv
module fau_phys_adder #(
  parameter int IP_W      = 16,
  parameter int SEG_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int PA_W      = 20
) (
  input  logic [SEG_W-1:0] seg,
  input  logic [IP_W-1:0]  off,
  output logic [PA_W-1:0]  phys
);
  localparam int SH_W = SEG_W + SEG_SHIFT;
  localparam int SUM_W = (SH_W > IP_W) ? SH_W : IP_W;

  logic [SUM_W-1:0] seg_sh, off_ext, sum;

  assign seg_sh  = SUM_W'({seg, {SEG_SHIFT{1'b0}}});
  assign off_ext = SUM_W'(off);
  assign sum     = seg_sh + off_ext;
  assign phys    = sum[PA_W-1:0];
endmodule

// File: rtl/fetch_addr_unit.sv
module fetch_addr_unit
  import fau_pkg::*;
#(
  parameter int IP_W      = 16,
  parameter int SEG_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int PA_W      = 20,
  parameter int QDEPTH    = 4,
  parameter logic [IP_W-1:0]  RESET_IP = '0,
  parameter logic [SEG_W-1:0] RESET_CS = '1,
  localparam int QL_W = $clog2(QDEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             q_room,
  output logic             fa_valid,
  input  logic             fa_ready,
  output logic [PA_W-1:0]  fa_addr,
  input  logic             corr_req,
  input  logic [QL_W-1:0]  q_len,
  input  logic             jmp_valid,
  output logic             jmp_ready,
  input  logic [IP_W-1:0]  jmp_ip,
  input  logic [SEG_W-1:0] jmp_cs,
  output logic [IP_W-1:0]  ip,
  output logic [SEG_W-1:0] cs,
  output logic             flush_req
);
  fau_op_e         op;
  logic [IP_W-1:0] corr_k;
  logic [IP_W-1:0] ip_next;
  logic [IP_W-1:0] ip_q;
  logic [SEG_W-1:0] cs_q;
  logic            flush_q;

  fau_arbiter u_arb (
    .rst_n     (rst_n),
    .corr_req  (corr_req),
    .jmp_valid (jmp_valid),
    .q_room    (q_room),
    .fa_ready  (fa_ready),
    .jmp_ready (jmp_ready),
    .fa_valid  (fa_valid),
    .op        (op)
  );

  fau_const_rom #(.IP_W(IP_W), .QDEPTH(QDEPTH), .QL_W(QL_W)) u_rom (
    .qlen   (q_len),
    .corr_k (corr_k)
  );

  fau_off_adder #(.IP_W(IP_W)) u_off (
    .op       (op),
    .ip_cur   (ip_q),
    .corr_k   (corr_k),
    .load_val (jmp_ip),
    .ip_next  (ip_next)
  );

  fau_phys_adder #(
    .IP_W(IP_W), .SEG_W(SEG_W), .SEG_SHIFT(SEG_SHIFT), .PA_W(PA_W)
  ) u_phys (
    .seg  (cs_q),
    .off  (ip_q),
    .phys (fa_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ip_q    <= RESET_IP;
      cs_q    <= RESET_CS;
      flush_q <= 1'b0;
    end else begin
      ip_q    <= ip_next;
      flush_q <= (op == OP_LOAD);
      if (op == OP_LOAD) cs_q <= jmp_cs;
    end
  end

  assign ip        = ip_q;
  assign cs        = cs_q;
  assign flush_req = flush_q;
endmodule

// File: rtl/fetch_addr_unit_chk.sv
module fetch_addr_unit_chk #(
  parameter int IP_W   = 16,
  parameter int SEG_W  = 16,
  parameter int PA_W   = 20,
  parameter int QDEPTH = 4,
  parameter int QL_W   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             q_room,
  input logic             fa_valid,
  input logic             fa_ready,
  input logic [PA_W-1:0]  fa_addr,
  input logic             corr_req,
  input logic [QL_W-1:0]  q_len,
  input logic             jmp_valid,
  input logic             jmp_ready,
  input logic [IP_W-1:0]  jmp_ip,
  input logic [SEG_W-1:0] jmp_cs,
  input logic [IP_W-1:0]  ip,
  input logic [SEG_W-1:0] cs,
  input logic             flush_req
);
  a_r4_fetch_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fa_valid && fa_ready) |=> ip == IP_W'($past(ip) + IP_W'(1)));

  a_r5_rewind: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_req && q_len <= QL_W'(QDEPTH)) |=> ip == IP_W'($past(ip) - IP_W'($past(q_len))));

  a_r6_corr_first: assert property (@(posedge clk) disable iff (!rst_n)
    corr_req |-> (!jmp_ready && !fa_valid));

  a_r6_seg_kept: assert property (@(posedge clk) disable iff (!rst_n)
    corr_req |=> $stable(cs));

  a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
    (jmp_valid && jmp_ready) |=> (ip == $past(jmp_ip) && cs == $past(jmp_cs) && flush_req));

  a_r7_flush_cause: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> $past(jmp_valid && jmp_ready));

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(fa_valid && fa_ready) && !corr_req && !jmp_valid) |=> ($stable(ip) && $stable(cs)));
endmodule

bind fetch_addr_unit fetch_addr_unit_chk #(
  .IP_W(IP_W), .SEG_W(SEG_W), .PA_W(PA_W), .QDEPTH(QDEPTH), .QL_W(QL_W)
) u_chk (.*);

// File: tb/fetch_addr_unit_test.sv
`timescale 1ns/1ps
module fetch_addr_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        q_room, fa_ready, corr_req, jmp_valid;
  logic [2:0]  q_len;
  logic [15:0] jmp_ip, jmp_cs;
  logic        fa_valid, jmp_ready, flush_req;
  logic [19:0] fa_addr;
  logic [15:0] ip, cs;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fetch_addr_unit uut (
    .clk(clk), .rst_n(rst_n), .q_room(q_room), .fa_valid(fa_valid),
    .fa_ready(fa_ready), .fa_addr(fa_addr), .corr_req(corr_req), .q_len(q_len),
    .jmp_valid(jmp_valid), .jmp_ready(jmp_ready), .jmp_ip(jmp_ip), .jmp_cs(jmp_cs),
    .ip(ip), .cs(cs), .flush_req(flush_req)
  );

  // {op[1:0], arg[15:0], qlen[2:0], expected ip[15:0]}; op 0 fetch, 1 correct, 2 jump
  localparam int NV = 14;
  localparam logic [36:0] VEC [NV] = '{
    {2'd0, 16'h0000, 3'd0, 16'h0001},
    {2'd0, 16'h0000, 3'd0, 16'h0002},
    {2'd0, 16'h0000, 3'd0, 16'h0003},
    {2'd1, 16'h0000, 3'd3, 16'h0000},
    {2'd2, 16'hFFFE, 3'd0, 16'hFFFE},
    {2'd0, 16'h0000, 3'd0, 16'hFFFF},
    {2'd0, 16'h0000, 3'd0, 16'h0000},
    {2'd1, 16'h0000, 3'd2, 16'hFFFE},
    {2'd1, 16'h0000, 3'd0, 16'hFFFE},
    {2'd1, 16'h0000, 3'd4, 16'hFFFA},
    {2'd1, 16'h0000, 3'd7, 16'hFFFA},
    {2'd2, 16'h0100, 3'd0, 16'h0100},
    {2'd0, 16'h0000, 3'd0, 16'h0101},
    {2'd1, 16'h0000, 3'd1, 16'h0100}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    q_room = 1'b0; fa_ready = 1'b0; corr_req = 1'b0; jmp_valid = 1'b0;
    q_len = '0; jmp_ip = '0; jmp_cs = '0;
  endtask

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    logic [20:0] t;
    t = {1'b0, s, 4'b0000} + {5'b0, o};
    return t[19:0];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] exp_cs;
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 ip", ip, 16'h0000);
    check("R1 cs", cs, 16'hFFFF);
    check("R1 addr", fa_addr, 20'hFFFF0);
    check("R1 flush", flush_req, 1'b0);
    exp_cs = 16'hFFFF;

    // Table walk: R2 R4 R5 R7
    for (int i = 0; i < NV; i++) begin
      logic [1:0] vop;
      vop = VEC[i][36:35];
      @(negedge clk);
      idle_inputs();
      if (vop == 2'd0) begin q_room = 1'b1; fa_ready = 1'b1; end
      else if (vop == 2'd1) begin corr_req = 1'b1; q_len = VEC[i][18:16]; end
      else begin jmp_valid = 1'b1; jmp_ip = VEC[i][34:19]; jmp_cs = 16'h2000; exp_cs = 16'h2000; end
      @(negedge clk);
      idle_inputs();
      #1;
      check(vop == 2'd1 ? "R5 ip" : (vop == 2'd2 ? "R7 ip" : "R4 ip"), ip, VEC[i][15:0]);
      check("R2 addr", fa_addr, phys(exp_cs, VEC[i][15:0]));
      check("R7 flush", flush_req, vop == 2'd2);
    end

    // R9 idle hold
    @(negedge clk);
    #1;
    check("R9 ip", ip, 16'h0100);
    check("R9 cs", cs, 16'h2000);

    // R3 no room
    @(negedge clk);
    q_room = 1'b0; fa_ready = 1'b1; #1;
    check("R3 valid no room", fa_valid, 1'b0);
    @(negedge clk); #1;
    check("R3 ip no room", ip, 16'h0100);

    // R3 back-pressure
    q_room = 1'b1; fa_ready = 1'b0; #1;
    check("R3 valid", fa_valid, 1'b1);
    @(negedge clk); #1;
    check("R3 ip held", ip, 16'h0100);
    idle_inputs();

    // R6 all three together
    @(negedge clk);
    q_room = 1'b1; fa_ready = 1'b1; corr_req = 1'b1; q_len = 3'd1;
    jmp_valid = 1'b1; jmp_ip = 16'h5555; jmp_cs = 16'h3000; #1;
    check("R6 jmp_ready", jmp_ready, 1'b0);
    check("R6 fa_valid", fa_valid, 1'b0);
    @(negedge clk);
    corr_req = 1'b0; #1;
    check("R6 ip", ip, 16'h00FF);
    check("R6 cs", cs, 16'h2000);
    check("R6 flush", flush_req, 1'b0);
    // jump still held, now alone
    jmp_ip = 16'h0010; jmp_cs = 16'hFFFF; #1;
    check("R6 jmp_ready after", jmp_ready, 1'b1);
    check("R3 valid blocked by jump", fa_valid, 1'b0);
    @(negedge clk);
    idle_inputs(); #1;
    check("R7 ip", ip, 16'h0010);
    check("R7 cs", cs, 16'hFFFF);
    check("R7 flush high", flush_req, 1'b1);
    check("R8 addr wrap", fa_addr, 20'h00000);
    @(negedge clk); #1;
    check("R7 flush one cycle", flush_req, 1'b0);

    // R1 reset mid-run
    rst_n = 1'b0;
    @(negedge clk); #1;
    check("R1 ip reset", ip, 16'h0000);
    check("R1 addr reset", fa_addr, 20'hFFFF0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule